// File: doc/BRIEF.md
# Binary FSK Square-Wave Modulator

This block turns a serial stream of data bits into a frequency-shift-keyed square-wave carrier. The carrier comes from a fractional clock divider. Each carrier period lasts either N or N+1 clocks. The choice between them is made by the carry out of a 24-bit phase accumulator, which adds a fixed increment once per period. The long-run division ratio is therefore N plus the increment divided by 2^24. Each of the two tones, mark and space, has its own divisor and its own increment. A data bit selects one pair, and the pair is applied as a single unit.

A symbol timer counts pulses of a base-rate tick input. When the configured number of ticks has passed, the block raises `bitReady` for one clock and takes the next data bit through a valid/ready handshake. If no bit is offered at that moment, the modulator falls back to the mark tone. A newly selected tone is taken up by the divider only at the end of the carrier period that is running, so no period is ever cut short. A symbol strobe marks each accepted bit.

Top module: `fsk_mod`

## Requirements
- R1: While `rstN` is low, `carrier`, `bitReady` and `symStrobe` are low. After reset the mark tone is selected, so the first carrier period is `markDiv` clocks long when `markInc` is zero.
- R2: `bitReady` is high for the one clock after the edge that counts the `symLen`-th tick of a symbol. Successive pulses are `symLen` ticks apart, and a `symLen` of 0 acts as 1.
- R3: A bit is accepted on an edge where `bitValid` and `bitReady` are both high. `symStrobe` is then high for exactly the next clock. At any other time `symStrobe` stays low.
- R4: An accepted `bitIn` of 1 selects the mark pair (`markDiv`, `markInc`). An accepted `bitIn` of 0 selects the space pair (`spaceDiv`, `spaceInc`).
- R5: If `bitValid` is low while `bitReady` is high, the next symbol is sent at the mark tone.
- R6: A tone change takes effect only at a carrier period boundary. Every period has the length of exactly one tone's divisor, or that divisor plus one, and divisor and increment always come from the same tone.
- R7: A period lasts N+1 clocks when adding the tone's increment to the 24-bit accumulator overflows, and N clocks otherwise. Starting from reset, the first K periods of a steady tone therefore span K·N + floor(K·inc / 2^24) clocks.
- R8: Within a period of L clocks, `carrier` is high for the first floor(L/2) clocks and low for the rest. Divisors must be at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Base-rate tick, one clock wide |
| symLen | input | SYM_W | Ticks per symbol |
| bitIn | input | 1 | Data bit (1 = mark, 0 = space) |
| bitValid | input | 1 | Data bit is offered |
| markDiv | input | DIV_W | Integer divisor for the mark tone |
| markInc | input | ACC_W | Accumulator increment for the mark tone |
| spaceDiv | input | DIV_W | Integer divisor for the space tone |
| spaceInc | input | ACC_W | Accumulator increment for the space tone |
| bitReady | output | 1 | One-clock request for the next bit |
| carrier | output | 1 | Square-wave carrier |
| symStrobe | output | 1 | One-clock pulse after a bit is accepted |

## Verification
The bench builds the block with its defaults: 16-bit divisors, a 24-bit accumulator and a 16-bit symbol count. The full accumulator width makes realistic fractional ratios reachable, such as a divisor of 258 with an increment near 0.0645·2^24, as well as the edge increments of zero, one half and 2^24−1. The tick input pulses every fourth clock, so the symbol lengths of 0, 5 and 20 ticks give ready spacings short enough to check exactly while still spanning several carrier periods. This also leaves room to watch a tone swap settle at a period boundary.

// File: rtl/fsk_pkg.sv
package fsk_pkg;
  // Control-to-datapath strobes: the tone the divider should use next.
  typedef struct packed {
    logic toneMark;
  } fskCtrl_t;
endpackage

// File: rtl/fsk_sym_ctrl.sv
module fsk_sym_ctrl
  import fsk_pkg::*;
#(
  parameter int SYM_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic [SYM_W-1:0] symLen,
  input  logic             bitIn,
  input  logic             bitValid,
  output logic             bitReady,
  output logic             symStrobe,
  output fskCtrl_t         ctrl
);
  logic [SYM_W-1:0] tickCnt;
  logic [SYM_W:0]   tickNext;
  logic             expire;
  logic             readyQ;
  logic             strobeQ;
  logic             toneMarkQ;

  assign tickNext = {1'b0, tickCnt} + 1'b1;
  // A zero length compares like a length of one.
  assign expire   = tick && (tickNext >= {1'b0, symLen});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
      readyQ  <= 1'b0;
    end else begin
      readyQ <= expire;
      if (tick) begin
        if (expire) tickCnt <= '0;
        else        tickCnt <= tickNext[SYM_W-1:0];
      end
    end
  end

  // Bit acceptance; idle symbols fall back to mark.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toneMarkQ <= 1'b1;
      strobeQ   <= 1'b0;
    end else begin
      strobeQ <= readyQ && bitValid;
      if (readyQ) toneMarkQ <= bitValid ? bitIn : 1'b1;
    end
  end

  assign bitReady      = readyQ;
  assign symStrobe     = strobeQ;
  assign ctrl.toneMark = toneMarkQ;
endmodule

// File: rtl/fsk_frac_div.sv
module fsk_frac_div
  import fsk_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  fskCtrl_t         ctrl,
  input  logic [DIV_W-1:0] markDiv,
  input  logic [ACC_W-1:0] markInc,
  input  logic [DIV_W-1:0] spaceDiv,
  input  logic [ACC_W-1:0] spaceInc,
  output logic             carrier,
  output logic             periodEnd,
  output logic             curMark,
  output logic [DIV_W:0]   perLen
);
  localparam int LEN_W = DIV_W + 1;

  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] len;
  logic [LEN_W:0]   cntNext;
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   accSum;
  logic [DIV_W-1:0] selDiv;
  logic [ACC_W-1:0] selInc;
  logic             curMarkQ;

  // Divisor and increment are chosen by the same select bit.
  always_comb begin
    if (ctrl.toneMark) begin
      selDiv = markDiv;
      selInc = markInc;
    end else begin
      selDiv = spaceDiv;
      selInc = spaceInc;
    end
  end

  assign cntNext   = {1'b0, cnt} + 1'b1;
  assign periodEnd = cntNext >= {1'b0, len};
  assign accSum    = {1'b0, acc} + {1'b0, selInc};

  // len resets to 1 so the first clock after reset loads the mark pair.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      len      <= LEN_W'(1);
      acc      <= '0;
      curMarkQ <= 1'b1;
    end else if (periodEnd) begin
      cnt      <= '0;
      acc      <= accSum[ACC_W-1:0];
      len      <= {1'b0, selDiv} + LEN_W'(accSum[ACC_W]);
      curMarkQ <= ctrl.toneMark;
    end else begin
      cnt <= cntNext[LEN_W-1:0];
    end
  end

  assign carrier = cnt < (len >> 1);
  assign curMark = curMarkQ;
  assign perLen  = len;
endmodule

// File: rtl/fsk_mod.sv
module fsk_mod
  import fsk_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int ACC_W = 24,
  parameter int SYM_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic [SYM_W-1:0] symLen,
  input  logic             bitIn,
  input  logic             bitValid,
  input  logic [DIV_W-1:0] markDiv,
  input  logic [ACC_W-1:0] markInc,
  input  logic [DIV_W-1:0] spaceDiv,
  input  logic [ACC_W-1:0] spaceInc,
  output logic             bitReady,
  output logic             carrier,
  output logic             symStrobe
);
  fskCtrl_t         ctrl;
  logic             periodEnd;
  logic             curMark;
  logic [DIV_W:0]   perLen;

  fsk_sym_ctrl #(.SYM_W(SYM_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .symLen(symLen),
    .bitIn(bitIn), .bitValid(bitValid),
    .bitReady(bitReady), .symStrobe(symStrobe), .ctrl(ctrl)
  );

  fsk_frac_div #(.DIV_W(DIV_W), .ACC_W(ACC_W)) u_div (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .markDiv(markDiv), .markInc(markInc),
    .spaceDiv(spaceDiv), .spaceInc(spaceInc),
    .carrier(carrier), .periodEnd(periodEnd),
    .curMark(curMark), .perLen(perLen)
  );
endmodule

// File: rtl/fsk_mod_chk.sv
module fsk_mod_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             tick,
  input logic             bitIn,
  input logic             bitValid,
  input logic             bitReady,
  input logic             carrier,
  input logic             symStrobe,
  input logic             toneReq,
  input logic             periodEnd,
  input logic             curMark,
  input logic [DIV_W:0]   perLen,
  input logic [DIV_W-1:0] markDiv,
  input logic [DIV_W-1:0] spaceDiv
);
  logic [DIV_W:0] baseLen;
  logic           lenOk;
  assign baseLen = curMark ? {1'b0, markDiv} : {1'b0, spaceDiv};
  assign lenOk   = (perLen == baseLen) || (perLen == baseLen + 1'b1);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |-> (!carrier && !bitReady && !symStrobe));

  a_r2_ready_after_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bitReady) |-> $past(tick));

  a_r3_accept_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (bitReady && bitValid) |=> symStrobe);

  a_r3_strobe_cause: assert property (@(posedge clk) disable iff (!rstN)
    symStrobe |-> $past(bitReady && bitValid));

  a_r4_space_select: assert property (@(posedge clk) disable iff (!rstN)
    (bitReady && bitValid && !bitIn) |=> !toneReq);

  a_r5_idle_mark: assert property (@(posedge clk) disable iff (!rstN)
    (bitReady && !bitValid) |=> toneReq);

  a_r6_tone_holds: assert property (@(posedge clk) disable iff (!rstN)
    !periodEnd |=> $stable(curMark));

  a_r6_pair_len: assert property (@(posedge clk) disable iff (!rstN)
    ($past(periodEnd) && $past(rstN)) |-> lenOk);
endmodule

bind fsk_mod fsk_mod_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .bitIn(bitIn), .bitValid(bitValid),
  .bitReady(bitReady), .carrier(carrier), .symStrobe(symStrobe),
  .toneReq(ctrl.toneMark), .periodEnd(periodEnd), .curMark(curMark),
  .perLen(perLen), .markDiv(markDiv), .spaceDiv(spaceDiv)
);

// File: tb/fsk_mod_tb.sv
module fsk_mod_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] symLen = 16'd5;
  logic        bitIn = 1'b1;
  logic        bitValid = 1'b0;
  logic [15:0] markDiv = 16'd10;
  logic [23:0] markInc = '0;
  logic [15:0] spaceDiv = 16'd14;
  logic [23:0] spaceInc = '0;
  logic        bitReady, carrier, symStrobe;

  int  nChk = 0;
  int  nFail = 0;
  bit  tickEn = 1'b0;
  bit  monEn = 1'b0;
  int  monBad = 0;

  always #2 clk = ~clk;

  fsk_mod u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .symLen(symLen),
    .bitIn(bitIn), .bitValid(bitValid),
    .markDiv(markDiv), .markInc(markInc),
    .spaceDiv(spaceDiv), .spaceInc(spaceInc),
    .bitReady(bitReady), .carrier(carrier), .symStrobe(symStrobe)
  );

  typedef struct packed {
    int div;
    int inc;
    int k;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{10, 0,        50},
    '{10, 8388608,  40},
    '{258, 1082401, 200},
    '{5,  16777215, 100},
    '{7,  5592405,  90}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Tick every fourth clock, driven away from the active edge.
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      tick = tickEn && (ph == 3);
      ph = (ph + 1) % 4;
    end
  end

  // Period monitor used for the no-truncation requirement.
  initial begin
    bit pc = 1'b0;
    int cur = 0;
    bit started = 1'b0;
    forever begin
      @(negedge clk);
      if (!monEn) begin
        started = 1'b0;
        cur = 0;
      end else if (!pc && carrier) begin
        if (started && cur != 10 && cur != 14) monBad++;
        started = 1'b1;
        cur = 1;
      end else begin
        cur++;
      end
      pc = carrier;
    end
  end

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitRise();
    bit p;
    p = carrier;
    @(negedge clk);
    while (!(!p && carrier)) begin
      p = carrier;
      @(negedge clk);
    end
  endtask

  // Called right at a rising edge; returns length and high time of the period.
  task automatic onePeriod(output int len, output int hi);
    bit p;
    len = 1; hi = 1; p = carrier;
    @(negedge clk);
    while (!(!p && carrier)) begin
      len++;
      if (carrier) hi++;
      p = carrier;
      @(negedge clk);
    end
  endtask

  task automatic waitReady();
    while (!bitReady) @(negedge clk);
  endtask

  initial begin
    int l, h;
    longint tot, expv;
    int gap;
    // R1: reset state
    @(negedge clk);
    chk(!carrier, "R1 carrier in reset", carrier, 0);
    chk(!bitReady, "R1 ready in reset", bitReady, 0);
    chk(!symStrobe, "R1 strobe in reset", symStrobe, 0);
    rstN = 1'b1;
    waitRise();
    onePeriod(l, h);
    chk(l == 10, "R1 first period at mark", l, 10);

    // R7: fractional ratio over many periods
    foreach (VECS[i]) begin
      rstN = 1'b0;
      markDiv = VECS[i].div[15:0];
      markInc = VECS[i].inc[23:0];
      doReset();
      waitRise();
      tot = 0;
      for (int k = 0; k < VECS[i].k; k++) begin
        onePeriod(l, h);
        tot += l;
      end
      expv = longint'(VECS[i].k) * VECS[i].div +
             ((longint'(VECS[i].k) * VECS[i].inc) >>> 24);
      chk(tot == expv, "R7 span of K periods", tot, expv);
    end

    // R8: duty cycle
    rstN = 1'b0; markDiv = 16'd10; markInc = '0;
    doReset(); waitRise(); onePeriod(l, h);
    chk(h == 5 && l == 10, "R8 high time div 10", h, 5);
    rstN = 1'b0; markDiv = 16'd7;
    doReset(); waitRise(); onePeriod(l, h);
    chk(h == 3 && l == 7, "R8 high time div 7", h, 3);

    // R2: ready spacing
    rstN = 1'b0; markDiv = 16'd10; symLen = 16'd5; tickEn = 1'b1;
    doReset();
    waitReady(); @(negedge clk);
    chk(!bitReady, "R2 ready one clock", bitReady, 0);
    gap = 1;
    while (!bitReady) begin @(negedge clk); gap++; end
    chk(gap == 20, "R2 ready spacing symLen 5", gap, 20);
    rstN = 1'b0; symLen = 16'd0;
    doReset();
    waitReady(); @(negedge clk);
    gap = 1;
    while (!bitReady) begin @(negedge clk); gap++; end
    chk(gap == 4, "R2 symLen 0 as 1", gap, 4);

    // FSK sequence: R3, R4, R5, R6
    rstN = 1'b0; symLen = 16'd20; spaceDiv = 16'd14; spaceInc = '0;
    doReset();
    monEn = 1'b1;
    waitReady(); @(negedge clk);
    bitValid = 1'b1; bitIn = 1'b0;
    waitReady();
    chk(!symStrobe, "R3 no strobe before accept", symStrobe, 0);
    @(negedge clk);
    chk(symStrobe, "R3 strobe after accept", symStrobe, 1);
    bitValid = 1'b0; bitIn = 1'b1;
    @(negedge clk);
    chk(!symStrobe, "R3 strobe one clock", symStrobe, 0);
    repeat (30) @(negedge clk);
    waitRise(); onePeriod(l, h);
    chk(l == 14, "R4 space period", l, 14);
    waitReady(); @(negedge clk);
    chk(!symStrobe, "R3 no strobe when idle", symStrobe, 0);
    repeat (30) @(negedge clk);
    waitRise(); onePeriod(l, h);
    chk(l == 10, "R5 idle sends mark", l, 10);
    // space again, then explicit mark
    bitValid = 1'b1; bitIn = 1'b0;
    waitReady(); @(negedge clk);
    bitValid = 1'b0;
    repeat (30) @(negedge clk);
    waitRise(); onePeriod(l, h);
    chk(l == 14, "R4 second space period", l, 14);
    bitValid = 1'b1; bitIn = 1'b1;
    waitReady(); @(negedge clk);
    chk(symStrobe, "R3 strobe on mark bit", symStrobe, 1);
    bitValid = 1'b0;
    repeat (30) @(negedge clk);
    waitRise(); onePeriod(l, h);
    chk(l == 10, "R4 mark bit period", l, 10);
    monEn = 1'b0;
    chk(monBad == 0, "R6 no truncated period", monBad, 0);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule